// File: doc/BRIEF.md
# Byte-Parallel Descrambler with Seed Recovery

This block undoes the additive scrambling applied to the data field of an OFDM packet, eight bits per clock. The scrambler is a seven-stage linear feedback shift register, so its output is a bit sequence with period 127. Instead of running a shift register, the block keeps an index into that sequence and XORs each received byte with the eight sequence bits that start at the index. The index then moves forward by eight, wrapping modulo 127.

The packet does not carry the scrambler seed directly. It is recovered from the data. The first seven bits of the service field are zero before scrambling, so the first seven received bits are a seven-bit window of the sequence itself. A 128-entry reverse table, built at elaboration, maps that window to its position in the sequence. A 127-entry byte table, also built at elaboration, supplies the XOR mask for each position. A window of all zeros cannot occur in the sequence. When it arrives, the block raises an error flag for the whole packet and passes the bytes through unchanged.

Top module: `dscr_byte_top`

## Requirements
- R1: The mask sequence follows the recurrence of the polynomial x^7 + x^4 + 1. Each new bit is the XOR of the bits produced 4 and 7 steps earlier. The sequence starts from the all-ones register state and repeats every 127 bits.
- R2: The mask for sequence position n is a byte whose bit k (k = 0 is the LSB) is sequence bit (n + k) mod 127. Bit 0 of every data byte is the earliest bit in time.
- R3: On a byte with `in_valid` and `in_sop` high, the key is `in_data[6:0]`. The block finds the position n whose sequence bits n..n+6 (bit 0 of the key is bit n, indices taken mod 127) equal the key. For every nonzero key, a well-formed first byte therefore descrambles to zeros in `out_data[6:0]`.
- R4: Each output byte is the input byte XOR the mask at its position. For the first byte of a packet, that position is the recovered n.
- R5: Each later valid byte of the packet uses the previous byte's position plus 8, modulo 127. A packet may run past 16 bytes and wrap around the period.
- R6: Each valid input byte gives exactly one output byte, one clock later. A cycle with `in_valid` low gives `out_valid` low one clock later and does not advance the position.
- R7: `out_sop` and `out_last` are `in_sop` and `in_last` of the same byte, delayed one clock. They are low whenever `out_valid` is low.
- R8: If the key of a start byte is zero, `out_err` is high on every output byte of that packet, and every such byte equals its input byte.
- R9: A new start byte always re-seeds the position and clears or sets the error state, even if the previous packet had no last byte.
- R10: While `rst_n` is low, `out_valid`, `out_sop`, `out_last`, `out_err` are low and `out_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte strobe |
| in_sop | input | 1 | Input byte is the first of a packet |
| in_last | input | 1 | Input byte is the last of a packet |
| in_data | input | 8 | Scrambled byte, bit 0 earliest |
| out_valid | output | 1 | Output byte strobe |
| out_sop | output | 1 | Output byte is the first of a packet |
| out_last | output | 1 | Output byte is the last of a packet |
| out_data | output | 8 | Descrambled byte |
| out_err | output | 1 | Packet key was zero, so the data is not descrambled |

## Verification
Every result of this block (the descrambled byte, its packet flags and the error flag) registers at the rising edge that samples the input byte. Each result is therefore due one clock after the stimulus. The bench changes inputs on the falling edge and checks the outputs of that byte on the next falling edge, half a period after they settle. Idle cycles are checked the same way, so `out_valid` is seen low exactly one clock after `in_valid` drops. Expected bytes come from a bit-serial shift register model in the bench, which scrambles random payloads from known seeds.

// File: rtl/dscr_pkg.sv
package dscr_pkg;

  localparam int LFSR_W  = 7;
  localparam int TAP_POS = 4;
  localparam int BYTE_W  = 8;
  localparam int SEQ_LEN = (1 << LFSR_W) - 1;
  localparam int KEY_CNT = 1 << LFSR_W;
  localparam int IDX_W   = LFSR_W;

  // Run the shift register from the all-ones state and keep the feedback bits.
  function automatic logic [SEQ_LEN-1:0] gen_seq_bits();
    logic [LFSR_W-1:0]  st;
    logic [SEQ_LEN-1:0] bits;
    logic               fb;
    st   = '1;
    bits = '0;
    for (int i = 0; i < SEQ_LEN; i++) begin
      fb      = st[TAP_POS-1] ^ st[LFSR_W-1];
      st      = {st[LFSR_W-2:0], fb};
      bits[i] = fb;
    end
    return bits;
  endfunction

  localparam logic [SEQ_LEN-1:0] SEQ_BITS = gen_seq_bits();

  // Mask byte for a position: consecutive bits, earliest in bit 0.
  function automatic logic [BYTE_W-1:0] seq_byte_at(input int pos);
    logic [BYTE_W-1:0] b;
    for (int k = 0; k < BYTE_W; k++) b[k] = SEQ_BITS[(pos + k) % SEQ_LEN];
    return b;
  endfunction

  // Position whose 7-bit window equals the key (0 for the impossible key).
  function automatic logic [IDX_W-1:0] seq_index_of(input int key);
    logic [LFSR_W-1:0] w;
    logic [IDX_W-1:0]  r;
    r = '0;
    for (int n = 0; n < SEQ_LEN; n++) begin
      for (int j = 0; j < LFSR_W; j++) w[j] = SEQ_BITS[(n + j) % SEQ_LEN];
      if (int'(w) == key) r = IDX_W'(n);
    end
    return r;
  endfunction

endpackage

// File: rtl/dscr_byte_rom.sv
module dscr_byte_rom
  import dscr_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  output logic [BYTE_W-1:0] mask
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);

  logic [BYTE_W-1:0] table_q [SEQ_LEN];

  for (genvar g = 0; g < SEQ_LEN; g++) begin : g_entry
    assign table_q[g] = seq_byte_at(g);
  end

  always_comb begin
    if (idx <= LAST_IDX) mask = table_q[idx];
    else                 mask = '0;
  end

endmodule

// File: rtl/dscr_seed_lut.sv
module dscr_seed_lut
  import dscr_pkg::*;
(
  input  logic [LFSR_W-1:0] key,
  output logic [IDX_W-1:0]  seed_idx,
  output logic              key_zero
);

  logic [IDX_W-1:0] lut [KEY_CNT];

  for (genvar g = 0; g < KEY_CNT; g++) begin : g_key
    assign lut[g] = seq_index_of(g);
  end

  assign seed_idx = lut[key];
  assign key_zero = (key == '0);

endmodule

// File: rtl/dscr_index_ctrl.sv
module dscr_index_ctrl
  import dscr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en,
  input  logic             start,
  input  logic [IDX_W-1:0] seed_idx,
  input  logic             seed_bad,
  output logic [IDX_W-1:0] cur_idx,
  output logic             cur_bad
);

  localparam int STEP = BYTE_W % SEQ_LEN;
  localparam logic [IDX_W:0] LEN_EXT  = (IDX_W+1)'(SEQ_LEN);
  localparam logic [IDX_W:0] STEP_EXT = (IDX_W+1)'(STEP);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             bad_q, bad_d;
  logic [IDX_W:0]   sum;

  always_comb begin
    cur_idx = start ? seed_idx : idx_q;
    cur_bad = start ? seed_bad : bad_q;
    sum     = {1'b0, cur_idx} + STEP_EXT;
    if (sum >= LEN_EXT) sum = sum - LEN_EXT;
    idx_d   = idx_q;
    bad_d   = bad_q;
    if (adv_en) begin
      idx_d = sum[IDX_W-1:0];
      bad_d = cur_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      bad_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      bad_q <= bad_d;
    end
  end

  assert_idx_in_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < IDX_W'(SEQ_LEN));

  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_en |=> $stable(idx_q));

endmodule

// File: rtl/dscr_byte_top.sv
module dscr_byte_top
  import dscr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_last,
  input  logic [BYTE_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_last,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_err
);

  logic [LFSR_W-1:0] key;
  logic [IDX_W-1:0]  seed_idx, cur_idx;
  logic              seed_bad, cur_bad;
  logic [BYTE_W-1:0] mask;

  logic              vld_q, sop_q, last_q, err_q;
  logic              vld_d, sop_d, last_d, err_d;
  logic [BYTE_W-1:0] data_q, data_d;

  assign key = in_data[LFSR_W-1:0];

  dscr_seed_lut u_seed (
    .key      (key),
    .seed_idx (seed_idx),
    .key_zero (seed_bad)
  );

  dscr_index_ctrl u_idx (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_en   (in_valid),
    .start    (in_sop),
    .seed_idx (seed_idx),
    .seed_bad (seed_bad),
    .cur_idx  (cur_idx),
    .cur_bad  (cur_bad)
  );

  dscr_byte_rom u_rom (
    .idx  (cur_idx),
    .mask (mask)
  );

  always_comb begin
    vld_d  = in_valid;
    sop_d  = in_valid & in_sop;
    last_d = in_valid & in_last;
    err_d  = in_valid & cur_bad;
    data_d = data_q;
    if (in_valid) data_d = cur_bad ? in_data : (in_data ^ mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      sop_q  <= 1'b0;
      last_q <= 1'b0;
      err_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q  <= vld_d;
      sop_q  <= sop_d;
      last_q <= last_d;
      err_q  <= err_d;
      data_q <= data_d;
    end
  end

  assign out_valid = vld_q;
  assign out_sop   = sop_q;
  assign out_last  = last_q;
  assign out_err   = err_q;
  assign out_data  = data_q;

  assert_byte_next_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_next_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_flags_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_sop == $past(in_sop)) && (out_last == $past(in_last)));

  assert_seed_clears_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sop && (in_data[LFSR_W-1:0] != '0)
      |=> (out_data[LFSR_W-1:0] == '0) && !out_err);

  assert_zero_key_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sop && (in_data[LFSR_W-1:0] == '0) |=> out_err);

  assert_err_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_data == $past(in_data));

endmodule

// File: tb/sim_dscr_byte_top.sv
module sim_dscr_byte_top;

  logic       clk, rst_n;
  logic       in_valid, in_sop, in_last;
  logic [7:0] in_data;
  logic       out_valid, out_sop, out_last, out_err;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;
  logic [6:0] lfsr;

  dscr_byte_top u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_sop(in_sop), .in_last(in_last), .in_data(in_data),
    .out_valid(out_valid), .out_sop(out_sop), .out_last(out_last),
    .out_data(out_data), .out_err(out_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Bit-serial scrambler model: x(t) = x(t-4) ^ x(t-7).
  function automatic logic [7:0] scramble(input logic [7:0] p);
    logic [7:0] s;
    logic x;
    for (int k = 0; k < 8; k++) begin
      x    = lfsr[3] ^ lfsr[6];
      lfsr = {lfsr[5:0], x};
      s[k] = p[k] ^ x;
    end
    return s;
  endfunction

  // Drive at a falling edge, check the result one clock later.
  task automatic put(input logic [7:0] d, input logic s, input logic l,
                     input logic [7:0] exp, input logic e, input string req);
    in_valid = 1'b1; in_sop = s; in_last = l; in_data = d;
    @(negedge clk);
    chk(out_valid === 1'b1, "R6", int'(out_valid), 1);
    chk(out_data === exp, req, int'(out_data), int'(exp));
    chk(out_sop === s && out_last === l, "R7", int'({out_sop, out_last}), int'({s, l}));
    chk(out_err === e, "R8", int'(out_err), int'(e));
  endtask

  task automatic idle();
    in_valid = 1'b0; in_sop = 1'b0; in_last = 1'b0; in_data = 8'hA5;
    @(negedge clk);
    chk(out_valid === 1'b0 && out_sop === 1'b0 && out_last === 1'b0, "R6",
        int'({out_valid, out_sop, out_last}), 0);
  endtask

  // One packet from a given seed; gap inserts idle cycles between bytes.
  task automatic send_pkt(input logic [6:0] seed, input int n, input int gap,
                          input logic with_last, input string req);
    logic [7:0] p;
    lfsr = seed;
    for (int i = 0; i < n; i++) begin
      p = (i == 0) ? {1'($urandom), 7'h00} : 8'($urandom);
      put(scramble(p), i == 0, with_last && (i == n - 1), p, 1'b0, req);
      for (int g = 0; g < gap; g++) idle();
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_last = 1'b0; in_data = 8'h00;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0 && out_sop === 1'b0 && out_last === 1'b0 && out_err === 1'b0,
        "R10", int'({out_valid, out_sop, out_last, out_err}), 0);
    chk(out_data === 8'h00, "R10", int'(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_single_byte();
    send_pkt(7'h7F, 1, 0, 1'b1, "R4");
    send_pkt(7'h01, 1, 0, 1'b1, "R4");
    idle();
  endtask

  // Every nonzero seed: covers each window, including those that wrap (R1 R2 R3).
  task automatic t_every_seed();
    for (int s = 1; s < 128; s++) send_pkt(7'(s), 3, 0, 1'b1, "R3");
    idle();
  endtask

  task automatic t_long_packet();
    send_pkt(7'($urandom_range(1, 127)), 300, 0, 1'b1, "R5");
    idle();
  endtask

  task automatic t_gaps();
    send_pkt(7'($urandom_range(1, 127)), 12, 2, 1'b1, "R6");
  endtask

  task automatic t_zero_key();
    put(8'h80, 1'b1, 1'b0, 8'h80, 1'b1, "R8");
    put(8'h5A, 1'b0, 1'b0, 8'h5A, 1'b1, "R8");
    idle();
    put(8'h33, 1'b0, 1'b1, 8'h33, 1'b1, "R8");
    put(8'h00, 1'b1, 1'b1, 8'h00, 1'b1, "R8");
    send_pkt(7'h2C, 4, 0, 1'b1, "R9");
    idle();
  endtask

  task automatic t_restart();
    send_pkt(7'h15, 5, 0, 1'b0, "R9");
    send_pkt(7'h6B, 6, 0, 1'b1, "R9");
    put(8'h00, 1'b1, 1'b0, 8'h00, 1'b1, "R9");
    send_pkt(7'h40, 3, 0, 1'b1, "R9");
    idle();
  endtask

  task automatic t_back_to_back();
    for (int i = 0; i < 20; i++)
      send_pkt(7'($urandom_range(1, 127)), 1 + i % 7, 0, 1'b1, "R4");
    idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_single_byte();
    t_every_seed();
    t_long_packet();
    t_gaps();
    t_zero_key();
    t_restart();
    t_back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule